// File: doc/BRIEF.md
# Register Redirection Table Expander

This block turns a short list of sixteen configuration slots into two full per-register lookup tables. One table covers the thirty-two integer register numbers and the other covers the thirty-two floating-point register numbers. Each slot names a register number and a table. It also carries the physical index that number should redirect to, an element width, a vector flag, a packed (SIMD) flag, a live bit and a bank bit. Issue logic presents a table select and a register number on the lookup pins. The same cycle it gets back the resolved entry. If no live slot covers that register, it gets back the register number unchanged.

A write to any slot triggers a full rebuild. The sequencer first empties both tables in one cycle. It then applies the slots one per cycle, lowest number first, so a later slot with the same key and table overrides an earlier one. The busy output stays high for the whole rebuild, and lookups made during that time report no redirection. The lookup is a single-cycle combinational read and carries no handshake. The configuration write is a plain strobe that is always accepted, and a write during a rebuild restarts it.

Top module: `reg_redirect_expander`

## Requirements
- R1: After reset, busy and rsvd_err are low, and every lookup in both tables reports no redirection.
- R2: A cfg_wr strobe sampled at a rising edge raises busy from the next cycle. Busy stays high for exactly 17 cycles: one clear cycle plus one apply cycle per slot.
- R3: While busy is high, every lookup reports lu_enabled low with the pass-through values of R4.
- R4: A lookup that finds no live entry returns lu_enabled=0, lu_phys equal to lu_reg with a zero sixth bit, and lu_ew, lu_vec and lu_packed all zero.
- R5: A live slot with cfg_type=0 fills the integer table at its key, and one with cfg_type=1 fills the floating-point table. The other table is left untouched at that key, and the filled entry reads back with lu_enabled=1.
- R6: The resolved index lu_phys equals the slot's redirection index plus 32 times its bank bit, so the bank bit lands in bit 5.
- R7: The slot's element width, vector flag and packed flag appear unchanged on lu_ew, lu_vec and lu_packed.
- R8: Every rebuild starts from empty tables, so a mapping disappears once its slot is rewritten with cfg_live=0.
- R9: When two live slots share both key and table, the higher-numbered slot determines the entry.
- R10: Different keys may point at the same physical index, and each of them resolves to that index.
- R11: rsvd_err is high exactly when at least one stored slot is live with its bank bit set. It follows slot writes from the next cycle.
- R12: A write that arrives during a rebuild restarts it, and busy then stays high for 17 cycles counted from the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one configuration slot |
| cfg_sel | input | 4 | Slot number being written |
| cfg_live | input | 1 | Slot takes part in the tables when set |
| cfg_type | input | 1 | Target table: 0 integer, 1 floating point |
| cfg_key | input | 5 | Register number the slot describes |
| cfg_idx | input | 5 | Redirection index |
| cfg_ew | input | 2 | Element width code, passed through |
| cfg_vec | input | 1 | Vector flag |
| cfg_packed | input | 1 | Packed (SIMD) flag |
| cfg_bank | input | 1 | Bank bit (bank 1 is reserved) |
| lu_type | input | 1 | Lookup table select: 0 integer, 1 floating point |
| lu_reg | input | 5 | Register number being looked up |
| lu_enabled | output | 1 | A live entry was found and no rebuild is running |
| lu_phys | output | 6 | Resolved physical register index |
| lu_ew | output | 2 | Resolved element width |
| lu_vec | output | 1 | Resolved vector flag |
| lu_packed | output | 1 | Resolved packed flag |
| busy | output | 1 | Rebuild in progress |
| rsvd_err | output | 1 | Some live slot selects the reserved bank |

## Verification
The bench uses the default build: sixteen slots, five-bit keys and indices, and a two-bit width code. This is small enough that all 64 table positions are swept after every configuration pattern and compared against a table the bench derives in slot order. The patterns exercise distinct keys across both tables, key collisions, shared targets, retired slots and the reserved bank. The same build also fixes the rebuild length at 17 cycles, so the busy window is counted exactly and the restart on an overlapping write can be checked.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int KEY_W  = 5;
  localparam int IDX_W  = 5;
  localparam int EW_W   = 2;
  localparam int PHYS_W = IDX_W + 1;
  localparam int NREGS  = 1 << KEY_W;

  typedef struct packed {
    logic             live;
    logic             kind;
    logic [KEY_W-1:0] key;
    logic [IDX_W-1:0] idx;
    logic [EW_W-1:0]  ew;
    logic             vec;
    logic             packd;
    logic             bank;
  } cfg_ent_t;

  typedef struct packed {
    logic              en;
    logic [PHYS_W-1:0] phys;
    logic [EW_W-1:0]   ew;
    logic              vec;
    logic              packd;
  } tbl_ent_t;
endpackage

// File: rtl/rr_cfg_store.sv
module rr_cfg_store
  import rr_pkg::*;
#(
  parameter int NUM_CFG = 16,
  localparam int SEL_W = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [SEL_W-1:0] wr_sel,
  input  cfg_ent_t         wr_ent,
  input  logic [SEL_W-1:0] rd_sel,
  output cfg_ent_t         rd_ent,
  output logic             rsvd_err
);
  cfg_ent_t slots [NUM_CFG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) slots[i] <= '0;
    end else if (wr) begin
      slots[wr_sel] <= wr_ent;
    end
  end

  assign rd_ent = slots[rd_sel];

  always_comb begin
    rsvd_err = 1'b0;
    for (int i = 0; i < NUM_CFG; i++) rsvd_err = rsvd_err | (slots[i].live & slots[i].bank);
  end

  // R11: a live reserved-bank write shows on the flag next cycle
  p_bank_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wr_ent.live && wr_ent.bank) |=> rsvd_err);
endmodule

// File: rtl/rr_rebuild_seq.sv
module rr_rebuild_seq #(
  parameter int NUM_CFG = 16,
  localparam int SEL_W = $clog2(NUM_CFG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             clr,
  output logic             apply,
  output logic [SEL_W-1:0] apply_sel
);
  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_APPLY} st_t;
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_CFG - 1);

  st_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      apply_sel <= '0;
    end else if (start) begin
      state     <= S_CLEAR;
      apply_sel <= '0;
    end else begin
      case (state)
        S_CLEAR: begin
          state     <= S_APPLY;
          apply_sel <= '0;
        end
        S_APPLY: begin
          if (apply_sel == LAST) state <= S_IDLE;
          else apply_sel <= apply_sel + SEL_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign clr   = (state == S_CLEAR) && !start;
  assign apply = (state == S_APPLY) && !start;

  // R2: a rebuild only begins because of a write
  p_busy_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R2: the last slot ends the rebuild
  p_last_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && apply_sel == LAST) |=> !busy);
  // R12: a write always puts the sequencer into the clear step
  p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !apply));
endmodule

// File: rtl/rr_table.sv
module rr_table
  import rr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr,
  input  logic [KEY_W-1:0] wr_key,
  input  tbl_ent_t         wr_ent,
  input  logic [KEY_W-1:0] rd_key,
  output tbl_ent_t         rd_ent
);
  tbl_ent_t         tbl [NREGS];
  logic [NREGS-1:0] en_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) tbl[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NREGS; i++) tbl[i] <= '0;
    end else if (wr) begin
      tbl[wr_key] <= wr_ent;
    end
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_en
    assign en_vec[g] = tbl[g].en;
  end

  assign rd_ent = tbl[rd_key];

  // R8: a clear step leaves no enabled entry
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($countones(en_vec) == 0));
  // R5: applying a slot adds at most one enabled entry
  p_one_per_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> ($countones(en_vec) <= $countones($past(en_vec)) + 1));
endmodule

// File: rtl/reg_redirect_expander.sv
module reg_redirect_expander
  import rr_pkg::*;
#(
  parameter int NUM_CFG = 16,
  localparam int SEL_W = $clog2(NUM_CFG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_live,
  input  logic              cfg_type,
  input  logic [KEY_W-1:0]  cfg_key,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [EW_W-1:0]   cfg_ew,
  input  logic              cfg_vec,
  input  logic              cfg_packed,
  input  logic              cfg_bank,
  input  logic              lu_type,
  input  logic [KEY_W-1:0]  lu_reg,
  output logic              lu_enabled,
  output logic [PHYS_W-1:0] lu_phys,
  output logic [EW_W-1:0]   lu_ew,
  output logic              lu_vec,
  output logic              lu_packed,
  output logic              busy,
  output logic              rsvd_err
);
  cfg_ent_t         wr_ent, cur;
  tbl_ent_t         apply_ent, hit;
  tbl_ent_t [1:0]   tbl_rd;
  logic             clr, apply;
  logic [SEL_W-1:0] apply_sel;

  assign wr_ent = '{live: cfg_live, kind: cfg_type, key: cfg_key, idx: cfg_idx,
                    ew: cfg_ew, vec: cfg_vec, packd: cfg_packed, bank: cfg_bank};

  rr_cfg_store #(.NUM_CFG(NUM_CFG)) i_store (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wr_sel(cfg_sel), .wr_ent(wr_ent),
    .rd_sel(apply_sel), .rd_ent(cur), .rsvd_err(rsvd_err)
  );

  rr_rebuild_seq #(.NUM_CFG(NUM_CFG)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(cfg_wr), .busy(busy),
    .clr(clr), .apply(apply), .apply_sel(apply_sel)
  );

  // bank bit lands above the 5-bit index: idx + bank*32
  assign apply_ent = '{en: 1'b1, phys: {cur.bank, cur.idx}, ew: cur.ew,
                       vec: cur.vec, packd: cur.packd};

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    rr_table i_tbl (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .wr(apply && cur.live && (cur.kind == 1'(t))),
      .wr_key(cur.key), .wr_ent(apply_ent),
      .rd_key(lu_reg), .rd_ent(tbl_rd[t])
    );
  end

  assign hit = tbl_rd[lu_type];

  always_comb begin
    if (busy || !hit.en) begin
      lu_enabled = 1'b0;
      lu_phys    = {1'b0, lu_reg};
      lu_ew      = '0;
      lu_vec     = 1'b0;
      lu_packed  = 1'b0;
    end else begin
      lu_enabled = 1'b1;
      lu_phys    = hit.phys;
      lu_ew      = hit.ew;
      lu_vec     = hit.vec;
      lu_packed  = hit.packd;
    end
  end

  // R3: no redirection is reported while rebuilding
  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !lu_enabled);
  // R4: a miss hands back the register number untouched
  p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_enabled |-> (lu_phys == {1'b0, lu_reg} && !lu_vec && !lu_packed && lu_ew == '0));
  // R1: tables come out of reset empty, so nothing resolves before a write
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(cfg_wr)) |-> (!busy && !rsvd_err));
endmodule

// File: tb/test_reg_redirect_expander.sv
module test_reg_redirect_expander;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_sel = '0;
  logic       cfg_live = 1'b0, cfg_type = 1'b0;
  logic [4:0] cfg_key = '0, cfg_idx = '0;
  logic [1:0] cfg_ew = '0;
  logic       cfg_vec = 1'b0, cfg_packed = 1'b0, cfg_bank = 1'b0;
  logic       lu_type = 1'b0;
  logic [4:0] lu_reg = '0;
  logic       lu_enabled, lu_vec, lu_packed, busy, rsvd_err;
  logic [5:0] lu_phys;
  logic [1:0] lu_ew;

  int checks = 0, errors = 0;
  bit done = 0;

  logic       m_live [16], m_kind [16], m_vec [16], m_pk [16], m_bank [16];
  logic [4:0] m_key [16], m_idx [16];
  logic [1:0] m_ew [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_redirect_expander i_reg_redirect_expander (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_live(cfg_live), .cfg_type(cfg_type), .cfg_key(cfg_key), .cfg_idx(cfg_idx),
    .cfg_ew(cfg_ew), .cfg_vec(cfg_vec), .cfg_packed(cfg_packed), .cfg_bank(cfg_bank),
    .lu_type(lu_type), .lu_reg(lu_reg), .lu_enabled(lu_enabled), .lu_phys(lu_phys),
    .lu_ew(lu_ew), .lu_vec(lu_vec), .lu_packed(lu_packed), .busy(busy), .rsvd_err(rsvd_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input int s, input logic lv, input logic kd, input logic [4:0] k,
                     input logic [4:0] ix, input logic [1:0] w, input logic v,
                     input logic p, input logic b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 4'(s); cfg_live = lv; cfg_type = kd; cfg_key = k;
    cfg_idx = ix; cfg_ew = w; cfg_vec = v; cfg_packed = p; cfg_bank = b;
    m_live[s] = lv; m_kind[s] = kd; m_key[s] = k; m_idx[s] = ix;
    m_ew[s] = w; m_vec[s] = v; m_pk[s] = p; m_bank[s] = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic sweep(input string req);
    logic [10:0] exp_t [2][32];
    logic [10:0] act;
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 32; r++) exp_t[t][r] = {1'b0, 1'b0, 5'(r), 2'b00, 1'b0, 1'b0};
    for (int e = 0; e < 16; e++)
      if (m_live[e])
        exp_t[m_kind[e]][m_key[e]] = {1'b1, m_bank[e], m_idx[e], m_ew[e], m_vec[e], m_pk[e]};
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 32; r++) begin
        @(negedge clk);
        lu_type = 1'(t); lu_reg = 5'(r);
        #1;
        act = {lu_enabled, lu_phys, lu_ew, lu_vec, lu_packed};
        check(act == exp_t[t][r], req, int'(act), int'(exp_t[t][r]));
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=busy expected=idle");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int e = 0; e < 16; e++) begin
      m_live[e] = 0; m_kind[e] = 0; m_key[e] = 0; m_idx[e] = 0;
      m_ew[e] = 0; m_vec[e] = 0; m_pk[e] = 0; m_bank[e] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(rsvd_err == 1'b0, "R1 rsvd_err", rsvd_err, 0);
    sweep("R1/R4 reset sweep");

    // R2: rebuild length after a single write
    put(0, 1, 0, 5'd9, 5'd20, 2'd3, 1, 1, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == 17, "R2 busy length", n, 17);

    // R3: lookups during rebuild report nothing
    put(1, 1, 1, 5'd4, 5'd11, 2'd1, 1, 0, 0);
    lu_type = 1'b0; lu_reg = 5'd9; #1;
    check(!lu_enabled && lu_phys == 6'd9, "R3 int key during busy", {lu_enabled, lu_phys}, 9);
    lu_type = 1'b1; lu_reg = 5'd4; #1;
    check(!lu_enabled && lu_phys == 6'd4, "R3 fp key during busy", {lu_enabled, lu_phys}, 4);
    wait_idle();

    // R12: overlapping write restarts the rebuild
    repeat (5) @(negedge clk);
    put(2, 0, 0, 5'd0, 5'd0, 2'd0, 0, 0, 0);
    repeat (6) @(negedge clk);
    put(2, 0, 1, 5'd1, 5'd1, 2'd0, 0, 0, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == 17, "R12 busy after restart", n, 17);

    // R5/R6/R7: distinct keys spread across both tables
    for (int i = 0; i < 16; i++)
      put(i, 1, 1'(i % 2), 5'((i * 7 + 3) % 32), 5'((i * 5 + 1) % 32), 2'(i % 4),
          1'((i >> 1) & 1), 1'((i >> 2) & 1), 0);
    wait_idle();
    sweep("R5/R6/R7 spread");

    // R8: retire even slots
    for (int i = 0; i < 16; i += 2) put(i, 0, m_kind[i], m_key[i], m_idx[i], m_ew[i], m_vec[i], m_pk[i], 0);
    wait_idle();
    sweep("R8 retired slots");

    // R9: colliding keys, higher slot wins
    for (int i = 0; i < 16; i++) put(i, 1, 0, 5'(i % 4), 5'(i + 10), 2'(3 - i % 4), 1, 0, 0);
    wait_idle();
    lu_type = 1'b0; lu_reg = 5'd2; #1;
    check(lu_enabled && lu_phys == 6'd24, "R9 key 2 from slot 14", lu_phys, 24);
    sweep("R9 collisions");

    // R10: many keys share one target
    for (int i = 0; i < 16; i++) put(i, 1, 1'(i / 8), 5'(i * 2), 5'd7, 2'd2, 0, 1, 0);
    wait_idle();
    sweep("R10 shared target");

    // R11/R6: reserved bank
    check(rsvd_err == 1'b0, "R11 no bank set", rsvd_err, 0);
    put(3, 1, 1, 5'd17, 5'd5, 2'd1, 1, 1, 1);
    check(rsvd_err == 1'b1, "R11 bank set", rsvd_err, 1);
    wait_idle();
    lu_type = 1'b1; lu_reg = 5'd17; #1;
    check(lu_enabled && lu_phys == 6'd37, "R6 bank adds 32", lu_phys, 37);
    sweep("R6/R11 bank sweep");
    put(3, 0, 1, 5'd17, 5'd5, 2'd1, 1, 1, 1);
    check(rsvd_err == 1'b0, "R11 dead slot ignores bank", rsvd_err, 0);
    wait_idle();
    sweep("R8/R11 bank retired");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule